// File: doc/BRIEF.md
# Prescaled Event Timer with Compare Match

This block is an 8-bit up-counting timer for a register-mapped peripheral. A free-running divider turns the input clock into a one-cycle timer tick at one of seven rates. A 3-bit rate code chooses the rate, and one code stops the timer. On every tick the counter advances by one and wraps after its maximum.

A compare register is checked against the counter on every tick. On a match the block latches a sticky interrupt flag and inverts a waveform output. Software reaches the rate code, the counter, the compare value and the flag through a small synchronous write port with a combinational read port. When software loads the counter, the match on the following tick is blocked. This keeps a fresh load from being taken as a compare event.

Top module: `tmr_unit`

## Requirements
- R1: After reset the rate code, counter, compare value, flag and waveform output all read zero.
- R2: With rate code 0 no ticks occur. The counter holds its value, and no match is raised even when the counter equals the compare value.
- R3: Rate codes 1 to 7 give exactly one tick every 1, 8, 32, 64, 128, 256 and 1024 input clock cycles, in that order. The counter advances by one on each tick.
- R4: The counter wraps from 255 to 0.
- R5: Register addresses: 0 holds the rate code in bits [2:0], 1 is the counter, 2 is the compare value, and 3 holds the flag in bit 0. A write takes effect at the clock edge on which bus_wr is high. A read returns the current value combinationally, and unused bits read zero.
- R6: A tick on which the counter equals the compare value is a match. At that same edge the flag is set and the waveform output inverts.
- R7: Writing 1 to bit 0 at address 3 clears the flag. Writing 0 there leaves the flag unchanged.
- R8: When a match and a flag clear fall on the same edge, the flag ends set.
- R9: A counter write wins over a tick at the same edge. The counter takes the written value.
- R10: A counter write suppresses any match at its own edge and on the next tick after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | Compare interrupt flag |
| wave_out | output | 1 | Waveform output, inverts on each match |

## Verification
Every register write and every tick takes effect at a single rising edge. A read reflects that edge at once through the combinational read path. So the counter, flag and waveform results are due one edge after the stimulus that causes them. The bench drives inputs at the falling edge and samples one nanosecond later, counting edges from the write that enabled the timer. For the slower rates it does not predict the prescaler phase. Instead it checks that any window of sixteen periods adds exactly sixteen to the counter.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int SEL_W = 3;
  localparam int NSEL  = 1 << SEL_W;

  // log2 of the division ratio for each rate code (code 0 unused)
  function automatic int rate_shift(input int code);
    case (code)
      2: rate_shift = 3;
      3: rate_shift = 5;
      4: rate_shift = 6;
      5: rate_shift = 7;
      6: rate_shift = 8;
      7: rate_shift = 10;
      default: rate_shift = 0;
    endcase
  endfunction

  // Low-bit mask of the divider that must be all ones for a tick
  function automatic logic [15:0] tap_mask(input int code);
    tap_mask = 16'((32'd1 << rate_shift(code)) - 32'd1);
  endfunction

  function automatic logic [7:0] count_next(input logic [7:0] c);
    count_next = c + 8'd1;
  endfunction

  typedef enum logic [1:0] {
    REG_RATE = 2'd0,
    REG_CNT  = 2'd1,
    REG_CMP  = 2'd2,
    REG_FLAG = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 10,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  import tmr_pkg::*;
  localparam int NCODE = 1 << SEL_W;

  logic [PRE_W-1:0] div_q;
  logic [NCODE-1:0] taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign taps[0] = 1'b0;
  for (genvar g = 1; g < NCODE; g++) begin : g_tap
    localparam logic [PRE_W-1:0] MASK = PRE_W'(tap_mask(g));
    assign taps[g] = ((div_q & MASK) == MASK);
  end

  assign tick = taps[sel];

  // R3: a 1-cycle rate (code 1) ticks on every cycle
  a_r3_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_W'(1)) |-> tick);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt
);
  import tmr_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (tick) cnt <= CNT_W'(count_next(8'(cnt)));
  end

  // R4: a tick without a load advances by one modulo 2^CNT_W
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
  // R9: a load wins over a tick at the same edge
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(ld_val)));
  // R2: no tick and no load keeps the count
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld) |=> $stable(cnt));
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_ld,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             flag_clr,
  output logic             match,
  output logic             flag,
  output logic             wave
);
  logic blk_q;

  // a load blocks the match at its own edge and at the next tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      blk_q <= 1'b0;
    else if (cnt_ld) blk_q <= 1'b1;
    else if (tick)   blk_q <= 1'b0;
  end

  assign match = tick && !cnt_ld && !blk_q && (cnt == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (match)    flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wave <= 1'b0;
    else if (match) wave <= ~wave;
  end

  // R8: a match always leaves the flag set, even with a clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag);
  // R6: each match inverts the waveform output
  a_r6_wave_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (wave != $past(wave)));
  // R7: a clear without a match empties the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !match) |=> !flag);
  // R10: the tick following a counter load never matches
  a_r10_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q && tick) |-> !match);
  // R2: without ticks there is no match
  a_r2_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> !match);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq,
  output logic             wave_out
);
  import tmr_pkg::*;

  logic [SEL_W-1:0] rate_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cnt;
  logic             tick;
  logic             match;
  logic             wr_rate, wr_cnt, wr_cmp, flag_clr;

  assign wr_rate  = bus_wr && (bus_addr == REG_RATE);
  assign wr_cnt   = bus_wr && (bus_addr == REG_CNT);
  assign wr_cmp   = bus_wr && (bus_addr == REG_CMP);
  assign flag_clr = bus_wr && (bus_addr == REG_FLAG) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (wr_rate) rate_q <= bus_wdata[SEL_W-1:0];
      if (wr_cmp)  cmp_q  <= bus_wdata;
    end
  end

  tmr_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(rate_q), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld(wr_cnt),
    .ld_val(bus_wdata), .cnt(cnt)
  );

  tmr_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_ld(wr_cnt),
    .cnt(cnt), .cmp(cmp_q), .flag_clr(flag_clr),
    .match(match), .flag(irq), .wave(wave_out)
  );

  always_comb begin
    case (bus_addr)
      REG_RATE: bus_rdata = CNT_W'(rate_q);
      REG_CNT:  bus_rdata = cnt;
      REG_CMP:  bus_rdata = cmp_q;
      default:  bus_rdata = CNT_W'(irq);
    endcase
  end

  // R2: a stopped timer leaves the counter alone unless it is written
  a_r2_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    ((rate_q == '0) && !wr_cnt) |=> $stable(cnt));
  // R5: a compare write is visible after its edge
  a_r5_cmp_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmp |=> (cmp_q == $past(bus_wdata)));
endmodule

// File: tb/sim_tmr_unit.sv
`timescale 1ns/1ps
module sim_tmr_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq, wave_out;

  always #4 clk = ~clk;

  tmr_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .wave_out(wave_out)
  );

  typedef struct {
    int         what;   // 0..3 register read, 4 irq pin, 5 wave pin
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  event  smp;
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  // monitor: pops each expected item and compares with the ports
  initial begin
    forever begin
      @(smp);
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.what)
          4:       act = {7'd0, irq};
          5:       act = {7'd0, wave_out};
          default: act = bus_rdata;
        endcase
        n_vec++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: item %0d actual %0d expected %0d",
                   it.tag, it.what, act, it.exp);
        end
      end
    end
  end

  // driver: select, let the read path settle, then hand over an item
  task automatic chk(input int what, input logic [7:0] exp, input string tag);
    item_t it;
    if (what < 4) bus_addr = 2'(what);
    #1;
    it.what = what; it.exp = exp; it.tag = tag;
    q.push_back(it);
    -> smp;
    #0;
  endtask

  // called at a falling edge; returns at the falling edge after the write
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek_cnt(output logic [7:0] v);
    bus_addr = 2'd1;
    #1;
    v = bus_rdata;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(0, 8'd0, "R1 rate");
    chk(1, 8'd0, "R1 counter");
    chk(2, 8'd0, "R1 compare");
    @(negedge clk);
    chk(3, 8'd0, "R1 flag reg");
    chk(4, 8'd0, "R1 irq");
    chk(5, 8'd0, "R1 wave");

    // R2 stopped: counter equals compare but nothing happens
    idle(20);
    chk(1, 8'd0, "R2 counter held");
    chk(4, 8'd0, "R2 no match");

    // R3 rate code 1: one tick per cycle
    @(negedge clk);
    wr(2'd2, 8'd200);
    wr(2'd0, 8'd1);
    chk(0, 8'd1, "R5 rate readback");
    chk(1, 8'd0, "R3 no tick on enabling edge");
    idle(10);
    chk(1, 8'd10, "R3 ratio 1");

    // R3 slower rates: any window of 16 periods yields 16 ticks
    for (int code = 2; code < 8; code++) begin
      int         per;
      logic [7:0] c0;
      case (code)
        2: per = 8;   3: per = 32;  4: per = 64;
        5: per = 128; 6: per = 256; default: per = 1024;
      endcase
      @(negedge clk);
      wr(2'(0), 8'(code));
      peek_cnt(c0);
      idle(16 * per);
      chk(1, c0 + 8'd16, $sformatf("R3 ratio %0d", per));
    end

    // R4 wrap
    @(negedge clk);
    wr(2'd0, 8'd0);
    wr(2'd1, 8'd254);
    wr(2'd0, 8'd1);
    idle(3);
    chk(1, 8'd1, "R4 wrap to 1 via 0");

    // R6 match
    @(negedge clk);
    wr(2'd0, 8'd0);
    wr(2'd3, 8'd1);
    wr(2'd2, 8'd10);
    wr(2'd1, 8'd7);
    wr(2'd0, 8'd1);
    idle(3);
    chk(1, 8'd10, "R6 counter at compare");
    chk(4, 8'd0, "R6 no flag before tick");
    @(negedge clk);
    chk(1, 8'd11, "R6 counter past compare");
    chk(4, 8'd1, "R6 flag set");
    chk(5, 8'd1, "R6 wave toggled");
    @(negedge clk);
    chk(3, 8'd1, "R5 flag reg bit0");

    // R7 writing 0 keeps, writing 1 clears
    @(negedge clk);
    wr(2'd3, 8'd0);
    chk(4, 8'd1, "R7 zero write ignored");
    @(negedge clk);
    wr(2'd3, 8'd1);
    chk(4, 8'd0, "R7 cleared");

    // R8 set wins over clear
    @(negedge clk);
    wr(2'd0, 8'd0);
    wr(2'd1, 8'd8);
    wr(2'd0, 8'd1);
    idle(2);
    wr(2'd3, 8'd1);
    chk(4, 8'd1, "R8 set wins");
    chk(5, 8'd0, "R8 wave toggled back");
    chk(1, 8'd11, "R8 counter advanced");
    @(negedge clk);
    wr(2'd3, 8'd1);
    chk(4, 8'd0, "R7 clear after set-wins");

    // R9 / R10 load while running on rate 1
    @(negedge clk);
    wr(2'd1, 8'd10);
    chk(1, 8'd10, "R9 load wins over tick");
    @(negedge clk);
    chk(1, 8'd11, "R10 counter moved past compare");
    chk(4, 8'd0, "R10 match suppressed");
    chk(5, 8'd0, "R10 wave unchanged");

    // R10 load at compare-1: the next tick is blocked only once
    @(negedge clk);
    wr(2'd2, 8'd20);
    wr(2'd1, 8'd19);
    idle(1);
    chk(1, 8'd20, "R10 one tick after load");
    @(negedge clk);
    chk(4, 8'd1, "R10 later tick matches");

    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule